// File: doc/BRIEF.md
# Transmitter Loop-Delay Compensated Bit Checker

This block sits beside the bit stream engine of a flexible data-rate CAN transmitter. During the fast data phase, a transmitted bit can take longer than one bit time to travel through the transceiver and come back on the receive line. A comparison at the regular sample point would then see the wrong bit. The block solves this in two steps. Once per frame it measures the loop delay in system clock cycles. A counter starts on the start strobe of the reserved bit that follows the format bit, and stops when the receive line shows the recessive-to-dominant edge between those two bits.

The measured delay plus a programmable offset gives a check distance. Every bit launched in the data phase is stored in a small queue together with the cycle at which its echo is due. At that cycle the stored value is compared with the receive line. A mismatch is held and handed to the frame state machine as a one-cycle error pulse after the next regular sample point. Outside the compensated data phase, the block falls back to a direct comparison of the transmit and receive lines at the sample point. The CRC delimiter bit is never queued. At the delimiter's sample point the queue is emptied.

Top module: `fd_loopback_checker`

## Requirements
- R1: After reset, `delay_out` is 0 and both `bit_err` and `ovf_err` are 0.
- R2: The measurement counts the clock edges from the edge that samples `meas_start` high up to and including the first edge that samples `rx_line` low when the previous edge sampled it high. That count appears on `delay_out` after that edge and holds until the next measurement ends.
- R3: If no falling receive edge arrives, the measurement stops at 2^DLY_W-1 and reports that value.
- R4: The compensated mode is active while `data_phase` and `comp_en` are both 1. In this mode, each `tx_bit_start` pushes the current `tx_bit`. That bit is compared with `rx_line` at the edge exactly S clock edges after its start edge, where S = `delay_out` + `ssp_offset`, clamped to the range 1..2^(DLY_W+1)-1.
- R5: A compensated mismatch is held until the next edge that samples `sample_pt`. `bit_err` (1 = error) is then high for exactly one cycle after that edge. A mismatch found on that same edge is included.
- R6: Up to DEPTH bits may be awaiting their check at once, so the check point may lie several bits after the end of the bit it checks.
- R7: A push while all DEPTH entries are waiting, with no check on the same edge, drops that bit unchecked. It also sets `ovf_err`, which stays 1 until the queue is cleared.
- R8: When the compensated mode is inactive, the edge that samples `sample_pt` sets `bit_err` for one cycle to `tx_bit` XOR `rx_line`.
- R9: A bit that starts while `crc_delim` is 1 is not queued. At the delimiter's sample point there is no direct comparison. The held error is reported, and every waiting entry is discarded, so checks that would have fallen later never fire.
- R10: `err_frame` empties the queue, drops any held error without reporting it, and clears `ovf_err`.
- R11: Leaving the compensated mode (`data_phase` or `comp_en` at 0) empties the queue and drops any held error without reporting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_bit | input | 1 | Value currently driven on the transmit line |
| tx_bit_start | input | 1 | One-cycle strobe at the start of each transmitted bit |
| rx_line | input | 1 | Synchronized receive line (0 = dominant) |
| sample_pt | input | 1 | One-cycle strobe at the regular sample point |
| meas_start | input | 1 | Strobe at the start of the reserved bit that begins the delay measurement |
| data_phase | input | 1 | High while the frame is in its fast data phase as transmitter |
| comp_en | input | 1 | Enables delayed checking |
| crc_delim | input | 1 | High during the CRC delimiter bit |
| err_frame | input | 1 | Strobe on entry to an error frame |
| ssp_offset | input | OFS_W | Offset added to the measured delay |
| delay_out | output | DLY_W | Last measured loop delay in clock cycles |
| bit_err | output | 1 | One-cycle bit error pulse after a sample point |
| ovf_err | output | 1 | Sticky queue overflow flag |

## Verification
Each input is applied on one rising edge and the outputs are read on the falling edge that follows. A delay result is read on the falling edge right after the edge that sees the receive line go low. An error pulse is expected only on the falling edge that follows a sample-point edge; on every other edge the expected value is 0. The bench keeps its own queue of due edges, computed as start edge plus the expected distance. It compares `bit_err` and `ovf_err` after every edge of a frame, so a pulse that comes one cycle early or late is caught as well as a missing one.

// File: rtl/fdlb_pkg.sv
package fdlb_pkg;

  typedef enum logic {MEAS_IDLE, MEAS_RUN} meas_state_e;

  // Check distance: delay plus offset, never below one cycle, capped at lim.
  function automatic int ssp_distance(input int dly, input int ofs, input int lim);
    int s;
    s = dly + ofs;
    if (s < 1)   s = 1;
    if (s > lim) s = lim;
    return s;
  endfunction

  // Circular pointer advance for a queue of arbitrary depth.
  function automatic int ptr_step(input int p, input int depth);
    return (p >= depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/fdlb_delay_meter.sv
module fdlb_delay_meter
  import fdlb_pkg::*;
#(
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_start,
  input  logic             rx_line,
  output logic [DLY_W-1:0] delay_out,
  output logic             busy
);

  localparam logic [DLY_W-1:0] DLY_MAX = '1;

  meas_state_e      st;
  logic [DLY_W-1:0] cnt;
  logic             rx_q;
  logic             rx_fall;

  assign rx_fall = rx_q & ~rx_line;
  assign busy    = (st == MEAS_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= MEAS_IDLE;
      cnt       <= '0;
      rx_q      <= 1'b1;
      delay_out <= '0;
    end else begin
      rx_q <= rx_line;
      if (meas_start) begin
        st  <= MEAS_RUN;
        cnt <= DLY_W'(1);
      end else if (st == MEAS_RUN) begin
        if (rx_fall) begin
          delay_out <= cnt;
          st        <= MEAS_IDLE;
        end else if (cnt == DLY_MAX) begin
          delay_out <= DLY_MAX;
          st        <= MEAS_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fdlb_due_fifo.sv
module fdlb_due_fifo
  import fdlb_pkg::*;
#(
  parameter  int DEPTH = 4,
  parameter  int TS_W  = 9,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [TS_W-1:0]  push_due,
  input  logic             push_val,
  input  logic [TS_W-1:0]  now,
  output logic             hit,
  output logic             head_val,
  output logic [CNT_W-1:0] fill,
  output logic             ovf_flag
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [TS_W-1:0]  due_q [DEPTH];
  logic             val_q [DEPTH];
  logic [PTR_W-1:0] rd, wr;
  logic             full, accept, ovf_evt;

  assign full     = (fill == CNT_W'(DEPTH));
  assign hit      = (fill != '0) && (due_q[rd] == now);
  assign head_val = val_q[rd];
  assign accept   = push && !flush && (!full || hit);
  assign ovf_evt  = push && !flush && full && !hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        due_q[i] <= '0;
        val_q[i] <= 1'b1;
      end else if (accept && (wr == PTR_W'(i))) begin
        due_q[i] <= push_due;
        val_q[i] <= push_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd       <= '0;
      wr       <= '0;
      fill     <= '0;
      ovf_flag <= 1'b0;
    end else if (flush) begin
      rd       <= '0;
      wr       <= '0;
      fill     <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (hit)    rd <= PTR_W'(ptr_step(int'(rd), DEPTH));
      if (accept) wr <= PTR_W'(ptr_step(int'(wr), DEPTH));
      case ({accept, hit})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      ovf_flag <= ovf_flag | ovf_evt;
    end
  end

endmodule

// File: rtl/fdlb_err_report.sv
module fdlb_err_report (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_pt,
  input  logic delayed,
  input  logic flush,
  input  logic mism,
  input  logic direct_mis,
  output logic bit_err,
  output logic pending
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_err <= 1'b0;
      pending <= 1'b0;
    end else begin
      bit_err <= 1'b0;
      if (sample_pt) begin
        bit_err <= delayed ? (pending | mism) : direct_mis;
        pending <= 1'b0;
      end else if (flush) begin
        pending <= 1'b0;
      end else begin
        pending <= pending | mism;
      end
    end
  end

endmodule

// File: rtl/fd_loopback_checker.sv
module fd_loopback_checker
  import fdlb_pkg::*;
#(
  parameter int DLY_W = 7,
  parameter int OFS_W = 6,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_bit,
  input  logic             tx_bit_start,
  input  logic             rx_line,
  input  logic             sample_pt,
  input  logic             meas_start,
  input  logic             data_phase,
  input  logic             comp_en,
  input  logic             crc_delim,
  input  logic             err_frame,
  input  logic [OFS_W-1:0] ssp_offset,
  output logic [DLY_W-1:0] delay_out,
  output logic             bit_err,
  output logic             ovf_err
);

  localparam int SSP_W   = DLY_W + 1;
  localparam int TS_W    = SSP_W + 1;
  localparam int SSP_MAX = (2 ** SSP_W) - 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  // Named internal events, also observed by the bound checker.
  logic [TS_W-1:0]  timer;
  logic [SSP_W-1:0] ssp;
  logic             delayed;
  logic             fifo_flush;
  logic             push;
  logic [TS_W-1:0]  push_due;
  logic             hit;
  logic             head_val;
  logic             mism;
  logic             direct_mis;
  logic [CNT_W-1:0] fifo_cnt;
  logic             meas_busy;
  logic             pending;

  assign ssp        = SSP_W'(ssp_distance(int'(delay_out), int'(ssp_offset), SSP_MAX));
  assign delayed    = data_phase & comp_en;
  assign fifo_flush = err_frame | ~delayed | (sample_pt & crc_delim);
  assign push       = tx_bit_start & delayed & ~crc_delim;
  assign push_due   = timer + TS_W'(ssp);
  assign mism       = hit & (head_val != rx_line);
  assign direct_mis = tx_bit ^ rx_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timer <= '0;
    else        timer <= timer + 1'b1;
  end

  fdlb_delay_meter #(.DLY_W(DLY_W)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_start (meas_start),
    .rx_line    (rx_line),
    .delay_out  (delay_out),
    .busy       (meas_busy)
  );

  fdlb_due_fifo #(.DEPTH(DEPTH), .TS_W(TS_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (fifo_flush),
    .push     (push),
    .push_due (push_due),
    .push_val (tx_bit),
    .now      (timer),
    .hit      (hit),
    .head_val (head_val),
    .fill     (fifo_cnt),
    .ovf_flag (ovf_err)
  );

  fdlb_err_report u_report (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_pt  (sample_pt),
    .delayed    (delayed),
    .flush      (fifo_flush),
    .mism       (mism),
    .direct_mis (direct_mis),
    .bit_err    (bit_err),
    .pending    (pending)
  );

endmodule

// File: rtl/fdlb_checker.sv
module fdlb_checker #(
  parameter  int DEPTH = 4,
  parameter  int DLY_W = 7,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_pt,
  input logic             crc_delim,
  input logic             err_frame,
  input logic             data_phase,
  input logic             meas_start,
  input logic             bit_err,
  input logic             ovf_err,
  input logic [DLY_W-1:0] delay_out,
  input logic             meas_busy,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             fifo_flush
);

  // R2: the delay result only moves while a measurement runs
  a_r2_delay_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!meas_busy && !meas_start) |=> $stable(delay_out));

  // R5 / R8: an error pulse only follows a sample point edge
  a_r5_err_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> $past(sample_pt));

  // R6: the queue never holds more than DEPTH entries
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= DEPTH);

  // R7: overflow stays set until the queue is cleared
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !fifo_flush) |=> ovf_err);

  // R9: the delimiter sample point leaves the queue empty
  a_r9_delim_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && crc_delim) |=> (fifo_cnt == '0));

  // R10: error frame entry clears queue and overflow
  a_r10_errframe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |=> (fifo_cnt == '0 && !ovf_err));

  // R11: outside the data phase nothing stays queued
  a_r11_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !data_phase |=> (fifo_cnt == '0));

endmodule

bind fd_loopback_checker fdlb_checker #(.DEPTH(DEPTH), .DLY_W(DLY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_pt  (sample_pt),
  .crc_delim  (crc_delim),
  .err_frame  (err_frame),
  .data_phase (data_phase),
  .meas_start (meas_start),
  .bit_err    (bit_err),
  .ovf_err    (ovf_err),
  .delay_out  (delay_out),
  .meas_busy  (meas_busy),
  .fifo_cnt   (fifo_cnt),
  .fifo_flush (fifo_flush)
);

// File: tb/fd_loopback_checker_test.sv
module fd_loopback_checker_test;

  localparam int DLY_W = 7;
  localparam int OFS_W = 6;
  localparam int DEPTH = 4;
  localparam logic [15:0] PAT = 16'hB38D;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tx_bit = 1'b1;
  logic             tx_bit_start = 1'b0;
  logic             rx_line = 1'b1;
  logic             sample_pt = 1'b0;
  logic             meas_start = 1'b0;
  logic             data_phase = 1'b0;
  logic             comp_en = 1'b1;
  logic             crc_delim = 1'b0;
  logic             err_frame = 1'b0;
  logic [OFS_W-1:0] ssp_offset = '0;
  logic [DLY_W-1:0] delay_out;
  logic             bit_err;
  logic             ovf_err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  fd_loopback_checker #(.DLY_W(DLY_W), .OFS_W(OFS_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .tx_bit_start(tx_bit_start),
    .rx_line(rx_line), .sample_pt(sample_pt), .meas_start(meas_start),
    .data_phase(data_phase), .comp_en(comp_en), .crc_delim(crc_delim),
    .err_frame(err_frame), .ssp_offset(ssp_offset), .delay_out(delay_out),
    .bit_err(bit_err), .ovf_err(ovf_err)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tx_bit = 1'b1; tx_bit_start = 1'b0; rx_line = 1'b1; sample_pt = 1'b0;
    meas_start = 1'b0; data_phase = 1'b0; comp_en = 1'b1; crc_delim = 1'b0;
    err_frame = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1", "delay_out", delay_out, 0);
    chk("R1", "bit_err", bit_err, 0);
    chk("R1", "ovf_err", ovf_err, 0);
  endtask

  // R2: loop edge arrives d edges after the start edge
  task automatic measure(input int d, input string req);
    rx_line = 1'b1;
    cyc();
    meas_start = 1'b1;
    cyc();
    meas_start = 1'b0;
    repeat (d - 1) cyc();
    rx_line = 1'b0;
    cyc();
    chk(req, "delay_out", delay_out, d);
    rx_line = 1'b1;
    cyc();
  endtask

  task automatic t_hold();
    for (int i = 0; i < 10; i++) begin
      rx_line = i[0];
      cyc();
    end
    rx_line = 1'b1;
    cyc();
    chk("R2", "delay_out held", delay_out, 5);
  endtask

  // R3
  task automatic t_saturate();
    rx_line = 1'b1;
    cyc();
    meas_start = 1'b1;
    cyc();
    meas_start = 1'b0;
    repeat (200) cyc();
    chk("R3", "delay_out saturated", delay_out, (2 ** DLY_W) - 1);
  endtask

  // Frame runner with an independent model of the queue and the error latch.
  task automatic run_frame(input string tag, input int nbits, input int bl, input int s_exp,
                           input int lat, input int f1, input int f2,
                           input int endk, input int endat, input bit delim_last);
    bit txh [0:511];
    int qd [0:7];
    bit qv [0:7];
    int qn;
    bit pend, ovf;
    int total;
    qn = 0; pend = 1'b0; ovf = 1'b0;
    total = (endk != 0) ? endat + 1 : nbits * bl + 12;
    for (int r = 0; r < total; r++) begin
      int b, p;
      bit start, sp, delim, dp, ef, tx, rx, pop, mism, expb, flush;
      b = r / bl; p = r % bl;
      start = (p == 0) && (b < nbits);
      sp    = (p == bl - 1);
      delim = delim_last && (b == nbits - 1);
      tx    = (b < nbits) ? PAT[b % 16] : 1'b1;
      txh[r] = tx;
      rx    = ((r >= lat) ? txh[r - lat] : 1'b1) ^ ((r == f1) || (r == f2));
      dp    = !(endk == 2 && r == endat);
      ef    = (endk == 1 && r == endat);
      tx_bit = tx; tx_bit_start = start; sample_pt = sp; crc_delim = delim;
      rx_line = rx; data_phase = dp; comp_en = 1'b1; err_frame = ef;
      pop   = (qn > 0) && (qd[0] == r);
      mism  = pop && (rx != qv[0]);
      expb  = sp ? (dp ? (pend | mism) : (tx != rx)) : 1'b0;
      flush = ef || !dp || (sp && delim);
      if (sp)         pend = 1'b0;
      else if (flush) pend = 1'b0;
      else            pend = pend | mism;
      if (pop) begin
        for (int i = 0; i < 7; i++) begin qd[i] = qd[i + 1]; qv[i] = qv[i + 1]; end
        qn--;
      end
      if (flush) begin
        qn = 0; ovf = 1'b0;
      end else if (start && !delim) begin
        if (qn < DEPTH) begin qd[qn] = r + s_exp; qv[qn] = tx; qn++; end
        else ovf = 1'b1;
      end
      cyc();
      chk(tag, "bit_err", bit_err, expb);
      chk(tag, "ovf_err", ovf_err, ovf);
    end
    idle_inputs();
    cyc();
    chk(tag, "bit_err after frame", bit_err, 0);
    chk(tag, "ovf_err after frame", ovf_err, 0);
  endtask

  // R8
  task automatic t_direct();
    idle_inputs();
    tx_bit = 1'b0; rx_line = 1'b1; sample_pt = 1'b1;
    cyc();
    chk("R8", "direct mismatch", bit_err, 1);
    sample_pt = 1'b0;
    cyc();
    chk("R8", "pulse width", bit_err, 0);
    tx_bit = 1'b1; sample_pt = 1'b1;
    cyc();
    chk("R8", "direct match", bit_err, 0);
    data_phase = 1'b1; comp_en = 1'b0; rx_line = 1'b0; sample_pt = 1'b1;
    cyc();
    chk("R8", "compensation disabled mismatch", bit_err, 1);
    idle_inputs();
    cyc();
    chk("R8", "idle", bit_err, 0);
  endtask

  initial begin
    t_reset();
    measure(5, "R2");
    t_hold();
    t_saturate();
    // R4: distance 5+3, echo latency 5, bit length 10, clean run
    measure(5, "R2");
    ssp_offset = 6'd3;
    run_frame("R4", 12, 10, 8, 5, -1, -1, 0, 0, 1'b0);
    // R5: corrupt a check edge (38) and a non-check edge (45)
    run_frame("R5", 12, 10, 8, 5, 38, 45, 0, 0, 1'b0);
    // R6: distance 12+2 spans more than three short bits
    measure(12, "R2");
    ssp_offset = 6'd2;
    run_frame("R6", 12, 4, 14, 12, -1, -1, 0, 0, 1'b0);
    run_frame("R6", 12, 4, 14, 12, 34, -1, 0, 0, 1'b0);
    // R9: delimiter last, corruption at 30 reported, at 34 discarded
    run_frame("R9", 8, 4, 14, 12, 30, 34, 0, 0, 1'b1);
    // R7: distance 12+10 with 2-cycle bits overflows the queue
    ssp_offset = 6'd10;
    run_frame("R7", 16, 2, 22, 21, -1, -1, 0, 0, 1'b0);
    // R10: error frame during overflow, and during a held mismatch
    run_frame("R10", 16, 2, 22, 21, -1, -1, 1, 20, 1'b0);
    measure(5, "R2");
    ssp_offset = 6'd3;
    run_frame("R10", 6, 10, 8, 5, 18, -1, 1, 18, 1'b0);
    // R11: data phase drop with a held mismatch
    run_frame("R11", 6, 10, 8, 5, 18, -1, 2, 18, 1'b0);
    t_direct();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule